// File: doc/BRIEF.md
# Always-On Wake Controller

This block sits in the always-on clock domain next to a processor core that can enter sleep. The core asks to sleep with a request strobe. The controller accepts the request only when no wake condition is pending. It then holds a sleep flag until one of four sources qualifies: a masked interrupt line, a level event, a rising edge on the non-maskable interrupt, or a small local timer. On wake it drops the flag, fires a one-cycle wake pulse and records which source caused the wake.

Interrupt lines are already in the always-on domain and are qualified combinationally. A line counts only when it is pending, enabled and its priority is strictly above a threshold. The event and non-maskable inputs can arrive from anywhere, so each passes through a two-flop synchronizer first. The event wakes on its synchronized level. The non-maskable input wakes only on a rising edge of its synchronized value. The local timer is a free-running counter clocked by the always-on clock, compared against a programmable value. A source that changes while the always-on clock is stopped is seen only once that clock runs again, so sources must stay asserted until then.

Top module: `aon_wake_unit`

## Requirements
- R1: After reset `sleeping` is 0, `wakePulse` is 0, `wakeCause` is 2'b00, and the timer counter is 0.
- R2: While awake, `sleepReq` high with no wake condition true sets `sleeping` on the next clock edge.
- R3: While awake, `sleepReq` is ignored if any wake condition is true in that cycle, so `sleeping` stays 0.
- R4: Interrupt line i qualifies only when `irqPend[i]` and `irqEn[i]` are both 1 and its priority field `irqPrio[i*PRIO_W +: PRIO_W]` is strictly greater than `prioThresh`. An equal priority does not qualify.
- R5: `evtIn` is active high and passes a two-flop synchronizer. Set before clock edge k while asleep, it produces the wake pulse right after edge k+2, with `wakeCause` 2'b01.
- R6: `nmiIn` wakes only on a rising edge of its synchronized value, with the same two-edge delay as R5 and `wakeCause` 2'b10. A level that is held high does not wake.
- R7: The timer counter starts at 0 when reset is released and counts up one per cycle. The timer qualifies when `tmrEn` is 1 and the counter is greater than or equal to `tmrCmp`, giving `wakeCause` 2'b11. With `tmrEn` at 0 it never qualifies.
- R8: When several sources qualify at the same edge, the cause follows the order non-maskable (2'b10), then interrupt (2'b00), then timer (2'b11), then event (2'b01).
- R9: Wake is evaluated only while `sleeping` is 1. A wake clears `sleeping` and raises `wakePulse` for exactly one cycle, at the same edge.
- R10: `wakeCause` holds its value until the next wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Core request to enter sleep |
| irqPend | input | NUM_IRQ | Pending interrupt lines |
| irqEn | input | NUM_IRQ | Per-line interrupt enable |
| irqPrio | input | NUM_IRQ*PRIO_W | Packed per-line priority, line i at bits i*PRIO_W upward |
| prioThresh | input | PRIO_W | Priority threshold; a line must exceed it |
| evtIn | input | 1 | Asynchronous wake event, active high |
| nmiIn | input | 1 | Asynchronous non-maskable interrupt, rising edge |
| tmrEn | input | 1 | Local timer wake enable |
| tmrCmp | input | TIMER_W | Timer compare value |
| sleeping | output | 1 | Core is held asleep |
| wakePulse | output | 1 | One-cycle wake strobe |
| wakeCause | output | 2 | Source of the last wake |

## Verification
The assertions assume that `irqPend`, `irqEn`, `irqPrio`, `prioThresh`, `tmrEn`, `tmrCmp` and `sleepReq` are synchronous to the always-on clock. Only `evtIn` and `nmiIn` may change at any time. The stimulus changes every input on the falling edge. Before each new sleep request it waits for the synchronizers to settle, so each requested sleep starts with no pending wake. The bench tests the timer compare only far below counter wrap, so the counter value follows directly from the number of cycles since reset.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    CAUSE_IRQ = 2'b00,
    CAUSE_EVT = 2'b01,
    CAUSE_NMI = 2'b10,
    CAUSE_TMR = 2'b11
  } cause_e;

  // qualified wake sources, one bit each, valid for the current cycle
  typedef struct packed {
    logic nmi;
    logic irq;
    logic tmr;
    logic evt;
  } hits_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCause;
  } ctrl_strobe_t;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int PRIO_W      = 3,
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        irqPend,
  input  logic [NUM_IRQ-1:0]        irqEn,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         prioThresh,
  input  logic                      evtIn,
  input  logic                      nmiIn,
  input  logic                      tmrEn,
  input  logic [TIMER_W-1:0]        tmrCmp,
  input  ctrl_strobe_t              strobe,
  output hits_t                     hits,
  output logic [1:0]                wakeCause
);
  // ---------------- interrupt qualification ----------------
  logic [NUM_IRQ-1:0] lineOk;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign lineOk[i] = irqPend[i] & irqEn[i] &
                       (irqPrio[i*PRIO_W +: PRIO_W] > prioThresh);
  end

  // ---------------- event / NMI synchronizers ----------------
  logic evtSync, nmiSync, nmiPrev;

  wake_sync #(.STAGES(SYNC_STAGES)) u_evtSync (
    .clk(clk), .rstN(rstN), .d(evtIn), .q(evtSync));
  wake_sync #(.STAGES(SYNC_STAGES)) u_nmiSync (
    .clk(clk), .rstN(rstN), .d(nmiIn), .q(nmiSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPrev <= 1'b0;
    else       nmiPrev <= nmiSync;
  end

  // ---------------- local timer ----------------
  logic [TIMER_W-1:0] tmrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmrCnt <= '0;
    else       tmrCnt <= tmrCnt + 1'b1;
  end

  always_comb begin
    hits.nmi = nmiSync & ~nmiPrev;
    hits.irq = |lineOk;
    hits.tmr = tmrEn & (tmrCnt >= tmrCmp);
    hits.evt = evtSync;
  end

  // ---------------- cause encoding and hold ----------------
  cause_e nextCause;
  cause_e causeQ;

  always_comb begin
    if      (hits.nmi) nextCause = CAUSE_NMI;
    else if (hits.irq) nextCause = CAUSE_IRQ;
    else if (hits.tmr) nextCause = CAUSE_TMR;
    else               nextCause = CAUSE_EVT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  causeQ <= CAUSE_IRQ;
    else if (strobe.latchCause) causeQ <= nextCause;
  end

  assign wakeCause = causeQ;

  // ---------------- assertions ----------------
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> tmrCnt == TIMER_W'($past(tmrCnt) + 1'b1));

  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rstN)
    hits.nmi |=> !hits.nmi);

  a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchCause && hits.nmi) |=> wakeCause == CAUSE_NMI);

  a_r8_irq_over_rest: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchCause && hits.irq && !hits.nmi) |=> wakeCause == CAUSE_IRQ);

  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCause |=> $stable(wakeCause));
endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepReq,
  input  hits_t        hits,
  output ctrl_strobe_t strobe,
  output logic         sleeping,
  output logic         wakePulse
);
  typedef enum logic {ST_AWAKE = 1'b0, ST_ASLEEP = 1'b1} state_e;

  state_e state;
  logic   anyHit;

  assign anyHit = |hits;

  always_comb begin
    strobe.latchCause = (state == ST_ASLEEP) && anyHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_AWAKE;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= 1'b0;
      case (state)
        ST_AWAKE:  if (sleepReq && !anyHit) state <= ST_ASLEEP;
        ST_ASLEEP: if (anyHit) begin
                     state     <= ST_AWAKE;
                     wakePulse <= 1'b1;
                   end
        default:   state <= ST_AWAKE;
      endcase
    end
  end

  assign sleeping = (state == ST_ASLEEP);

  // ---------------- assertions ----------------
  a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && sleepReq && !anyHit) |=> sleeping);

  a_r3_pending_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && anyHit) |=> !sleeping);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  a_r9_pulse_leaves_sleep: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!sleeping && $past(sleeping)));

  a_r9_awake_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !sleeping |=> !wakePulse);
endmodule

// File: rtl/aon_wake_unit.sv
module aon_wake_unit
  import wake_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int PRIO_W      = 3,
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sleepReq,
  input  logic [NUM_IRQ-1:0]        irqPend,
  input  logic [NUM_IRQ-1:0]        irqEn,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         prioThresh,
  input  logic                      evtIn,
  input  logic                      nmiIn,
  input  logic                      tmrEn,
  input  logic [TIMER_W-1:0]        tmrCmp,
  output logic                      sleeping,
  output logic                      wakePulse,
  output logic [1:0]                wakeCause
);
  hits_t        hits;
  ctrl_strobe_t strobe;

  wake_datapath #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W),
    .TIMER_W(TIMER_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .irqPend(irqPend), .irqEn(irqEn), .irqPrio(irqPrio), .prioThresh(prioThresh),
    .evtIn(evtIn), .nmiIn(nmiIn), .tmrEn(tmrEn), .tmrCmp(tmrCmp),
    .strobe(strobe), .hits(hits), .wakeCause(wakeCause)
  );

  wake_control u_ctl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .hits(hits),
    .strobe(strobe), .sleeping(sleeping), .wakePulse(wakePulse)
  );
endmodule

// File: tb/sim_aon_wake_unit.sv
module sim_aon_wake_unit;
  localparam int NI = 8, PW = 3, TW = 16;

  logic clk = 0, rstN = 0, sleepReq = 0, evtIn = 0, nmiIn = 0, tmrEn = 0;
  logic [NI-1:0] irqPend = '0, irqEn = '0;
  logic [NI*PW-1:0] irqPrio = '0;
  logic [PW-1:0] prioThresh = '0;
  logic [TW-1:0] tmrCmp = '1;
  logic sleeping, wakePulse;
  logic [1:0] wakeCause;

  aon_wake_unit u0 (.*);

  always #2 clk = ~clk;   // 250 MHz

  int total = 0, failed = 0, cyc = 0;
  bit finished = 0;
  logic [1:0] expQ[$];

  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic goSleep();
    @(negedge clk) sleepReq = 1;
    tick();
    chk(sleeping == 1, "R2 enter sleep", sleeping, 1);
    @(negedge clk) sleepReq = 0;
  endtask

  task automatic setLine(input int idx, input bit pend, input bit en, input int prio);
    irqPend[idx] = pend;
    irqEn[idx] = en;
    irqPrio[idx*PW +: PW] = PW'(prio);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  // monitor: every wake pulse is matched against the next expected cause
  initial begin
    forever begin
      tick();
      if (wakePulse) begin
        chk(sleeping == 0, "R9 flag cleared with pulse", sleeping, 0);
        if (expQ.size() == 0)
          chk(0, "R9 unexpected wake", 1, 0);
        else begin
          logic [1:0] e;
          e = expQ.pop_front();
          chk(wakeCause == e, "R8 wake cause", wakeCause, e);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    chk(0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    int cmpVal;
    int n;
    waitN(2);
    // R1 reset state
    chk(sleeping == 0, "R1 sleeping", sleeping, 0);
    chk(wakePulse == 0, "R1 wakePulse", wakePulse, 0);
    chk(wakeCause == 2'b00, "R1 cause", wakeCause, 0);
    @(negedge clk) rstN = 1;
    tick();

    // R4: disabled line and equal priority do not wake
    prioThresh = 3'd3;
    goSleep();
    @(negedge clk) setLine(2, 1, 0, 5);
    waitN(4);
    chk(sleeping == 1, "R4 disabled line ignored", sleeping, 1);
    @(negedge clk) setLine(2, 1, 1, 3);
    waitN(4);
    chk(sleeping == 1, "R4 equal priority ignored", sleeping, 1);
    expQ.push_back(2'b00);
    @(negedge clk) setLine(2, 1, 1, 4);
    tick();
    chk(wakePulse == 1, "R4 qualified line wakes", wakePulse, 1);
    tick();
    chk(wakePulse == 0, "R9 pulse one cycle", wakePulse, 0);

    // R3: sleep request ignored with a pending wake
    @(negedge clk) sleepReq = 1;
    tick();
    chk(sleeping == 0, "R3 request ignored", sleeping, 0);
    @(negedge clk) begin sleepReq = 0; setLine(2, 0, 0, 0); end
    tick();

    // R5: event wakes after synchronizer delay
    goSleep();
    expQ.push_back(2'b01);
    @(negedge clk) evtIn = 1;
    waitN(2);
    chk(sleeping == 1, "R5 sync latency", sleeping, 1);
    tick();
    chk(wakePulse == 1, "R5 event wake", wakePulse, 1);
    @(negedge clk) evtIn = 0;
    waitN(4);
    chk(wakeCause == 2'b01, "R10 cause held", wakeCause, 1);

    // R6: held NMI level does not wake; a new rising edge does
    @(negedge clk) nmiIn = 1;
    waitN(4);
    goSleep();
    waitN(5);
    chk(sleeping == 1, "R6 held level ignored", sleeping, 1);
    @(negedge clk) nmiIn = 0;
    waitN(3);
    expQ.push_back(2'b10);
    @(negedge clk) nmiIn = 1;
    waitN(2);
    chk(sleeping == 1, "R6 sync latency", sleeping, 1);
    tick();
    chk(wakePulse == 1, "R6 edge wake", wakePulse, 1);
    @(negedge clk) nmiIn = 0;
    waitN(4);

    // R7: timer disabled never wakes, enabled compare wakes at exact cycle
    @(negedge clk) begin tmrCmp = '0; tmrEn = 0; end
    goSleep();
    waitN(4);
    chk(sleeping == 1, "R7 disabled timer ignored", sleeping, 1);
    expQ.push_back(2'b11);
    @(negedge clk) tmrEn = 1;
    tick();
    chk(wakePulse == 1, "R7 timer wake", wakePulse, 1);
    @(negedge clk) begin
      tmrEn = 1;
      cmpVal = cyc + 30;
      tmrCmp = TW'(cmpVal);
    end
    goSleep();
    expQ.push_back(2'b11);
    n = 0;
    while (!wakePulse && n < 100) begin tick(); n++; end
    chk(cyc == cmpVal + 1, "R7 compare cycle", cyc, cmpVal + 1);
    @(negedge clk) tmrEn = 0;
    tick();

    // R8: interrupt beats timer
    goSleep();
    expQ.push_back(2'b00);
    @(negedge clk) begin setLine(5, 1, 1, 7); tmrCmp = '0; tmrEn = 1; end
    tick();
    chk(wakePulse == 1, "R8 irq+timer wake", wakePulse, 1);
    @(negedge clk) begin setLine(5, 0, 0, 0); tmrEn = 0; end
    tick();

    // R8: NMI beats interrupt
    goSleep();
    expQ.push_back(2'b10);
    @(negedge clk) nmiIn = 1;
    waitN(2);
    @(negedge clk) setLine(0, 1, 1, 6);
    tick();
    chk(wakePulse == 1, "R8 nmi+irq wake", wakePulse, 1);
    @(negedge clk) begin setLine(0, 0, 0, 0); nmiIn = 0; end
    waitN(4);

    // R8: timer beats event
    goSleep();
    expQ.push_back(2'b11);
    @(negedge clk) evtIn = 1;
    waitN(2);
    @(negedge clk) begin tmrCmp = '0; tmrEn = 1; end
    tick();
    chk(wakePulse == 1, "R8 timer+event wake", wakePulse, 1);
    @(negedge clk) begin evtIn = 0; tmrEn = 0; end
    waitN(5);

    chk(expQ.size() == 0, "R9 all expected wakes seen", expQ.size(), 0);
    finish();
  end
endmodule